// File: doc/BRIEF.md
# Serial Command EEPROM Responder

This block stands in for a small serial EEPROM of 64 words by 16 bits. Software drives it through a single control register instead of real pins. Each write to the register carries a clock bit, a chip-select bit and a data-in bit. The block treats a change of the clock bit between two writes as a clock edge. Reading the register returns the data-out bit together with the stored control bits and two status bits that are always set.

A transaction is a 9-bit command sent most significant bit first: a 3-bit opcode followed by a 6-bit word address. Only the read opcode is understood. Once a read command has been taken, every falling clock edge moves the output to the next bit. Bits come out most significant bit first, and the stream runs on into the following words, wrapping from the last word back to word 0. A rising edge with chip-select low abandons any transaction. Word contents are written from a parallel initialisation port, one word per cycle.

Top module: `mw_eeprom_resp`

## Requirements
- R1: The read value `rd_data` always has bit 8 (present) and bit 7 (grant) set. It also shows the last written values of bit 0 (clock), bit 1 (chip-select), bit 2 (data-in), bits 5:4 (write-enable) and bit 6 (request). Bit 3 carries data-out, and all other bits read 0.
- R2: A register write whose bit 0 equals the stored clock bit only updates the stored bits; the protocol state and data-out do not change.
- R3: A falling clock edge (bit 0 going from 1 to 0) advances the output bit pointer by exactly one.
- R4: A rising clock edge with bit 1 low clears the shift value, the bit count, the pointer and the reading state, so data-out returns to 1.
- R5: A rising clock edge with bit 1 high shifts bit 2 into the command LSB-first, so the first bit sent ends up as the command MSB. Fewer than 9 such edges never start a read.
- R6: On the 9th shifted bit, when not already reading, command bits 8:6 equal to 3'b110 start a read. The pointer is then loaded with address×16−1, where the address is command bits 5:0. Before the next falling edge, data-out is bit 0 of word address−1 (word 63 for address 0). After that edge it is bit 15 of the addressed word.
- R7: A 9-bit command whose opcode is not 3'b110 leaves data-out at 1.
- R8: While no read is active, data-out reads 1.
- R9: During a read, data-out is bit (15 − pointer[3:0]) of word pointer[9:4]. The stream continues into the next word, and from word 63 into word 0.
- R10: Further rising edges with chip-select high during a read, whatever their data-in value, do not reload the pointer or disturb the stream.
- R11: An init-port write (`init_we` with `init_addr`, `init_word`) replaces that word. The next data-out sample taken from that word uses the new contents, even if the write lands on the same cycle as a falling clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| rd_data | output | 16 | Control register read value |
| init_we | input | 1 | Init-port word write strobe |
| init_addr | input | 6 | Init-port word address |
| init_word | input | 16 | Init-port word value |

## Verification
The two functions that can meet in one cycle are the init port loading a word and a falling clock edge moving the pointer into that same word. The bench starts a read of a word and samples a few of its bits. It then drives a falling-edge register write and an init-port write of the word being streamed on the same clock. Every remaining bit of that word is then compared against the newly loaded value, never the old one.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int CTRL_W = 16;

  localparam int CLK_B  = 0;
  localparam int CS_B   = 1;
  localparam int DI_B   = 2;
  localparam int DO_B   = 3;
  localparam int WEL_B  = 4;
  localparam int WEH_B  = 5;
  localparam int REQ_B  = 6;
  localparam int GNT_B  = 7;
  localparam int PRS_B  = 8;

  localparam logic [CTRL_W-1:0] KEEP_MASK =
      CTRL_W'((1 << CLK_B) | (1 << CS_B) | (1 << DI_B) |
              (1 << WEL_B) | (1 << WEH_B) | (1 << REQ_B));
  localparam logic [CTRL_W-1:0] FIXED_SET =
      CTRL_W'((1 << PRS_B) | (1 << GNT_B));

  localparam int          OP_W      = 3;
  localparam logic [2:0]  RD_OPCODE = 3'b110;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ABORT = 2'd1,
    EV_SHIFT = 2'd2,
    EV_FALL  = 2'd3
  } clk_ev_e;
endpackage

// File: rtl/mw_edge_ctl.sv
module mw_edge_ctl
  import mw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output clk_ev_e           ev,
  output logic              di_bit
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              clk_flip;

  assign ctrl_d   = wr_data & KEEP_MASK;
  assign clk_flip = wr_en && (wr_data[CLK_B] != ctrl_q[CLK_B]);
  assign di_bit   = wr_data[DI_B];

  always_comb begin
    ev = EV_NONE;
    if (clk_flip) begin
      if (!wr_data[CLK_B])     ev = EV_FALL;
      else if (!wr_data[CS_B]) ev = EV_ABORT;
      else                     ev = EV_SHIFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/mw_cmd_seq.sv
module mw_cmd_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BIT_W  = 4,
  localparam int CMD_W = OP_W + ADDR_W,
  localparam int PTR_W = ADDR_W + BIT_W,
  localparam int CNT_W = $clog2(CMD_W + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_ev_e          ev,
  input  logic             di,
  output logic [PTR_W-1:0] ptr_q,
  output logic             reading_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CMD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_d;
  logic [PTR_W-1:0] ptr_d;
  logic             reading_d;

  always_comb begin
    shift_d   = shift_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    reading_d = reading_q;
    unique case (ev)
      EV_FALL: ptr_d = ptr_q + PTR_W'(1);
      EV_ABORT: begin
        shift_d   = '0;
        cnt_d     = '0;
        ptr_d     = '0;
        reading_d = 1'b0;
      end
      EV_SHIFT: begin
        shift_d = {shift_q[CMD_W-2:0], di};
        if (cnt_q != '1) cnt_d = cnt_q + CNT_W'(1);
        if ((cnt_q == CNT_W'(CMD_W - 1)) && !reading_q) begin
          ptr_d     = {shift_d[ADDR_W-1:0], {BIT_W{1'b0}}} - PTR_W'(1);
          reading_d = (shift_d[CMD_W-1 -: OP_W] == RD_OPCODE);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      reading_q <= 1'b0;
    end else if (ev != EV_NONE) begin
      shift_q   <= shift_d;
      cnt_q     <= cnt_d;
      ptr_q     <= ptr_d;
      reading_q <= reading_d;
    end
  end
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PTR_W = ADDR_W + BIT_W
) (
  input  logic              clk,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [WORD_W-1:0] init_word,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              reading,
  output logic              dout
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] cur_word;
  logic [BIT_W-1:0]  bit_sel;

  always_ff @(posedge clk) begin
    if (init_we) mem[init_addr] <= init_word;
  end

  assign cur_word = mem[ptr[PTR_W-1:BIT_W]];
  assign bit_sel  = BIT_W'(WORD_W - 1) - ptr[BIT_W-1:0];
  assign dout     = !reading || cur_word[bit_sel];
endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int PTR_W = ADDR_W + BIT_W,
  localparam int CNT_W = $clog2(OP_W + ADDR_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [WORD_W-1:0] init_word
);
  logic [CTRL_W-1:0] ctrl_q;
  clk_ev_e           ev;
  logic              di_bit;
  logic [PTR_W-1:0]  seq_ptr;
  logic              seq_reading;
  logic [CNT_W-1:0]  seq_cnt;
  logic              dout;

  mw_edge_ctl u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .ev     (ev),
    .di_bit (di_bit)
  );

  mw_cmd_seq #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .di       (di_bit),
    .ptr_q    (seq_ptr),
    .reading_q(seq_reading),
    .cnt_q    (seq_cnt)
  );

  mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk      (clk),
    .init_we  (init_we),
    .init_addr(init_addr),
    .init_word(init_word),
    .ptr      (seq_ptr),
    .reading  (seq_reading),
    .dout     (dout)
  );

  assign rd_data = ctrl_q | FIXED_SET | (CTRL_W'(dout) << DO_B);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CTRL_W-1:0] rd_data,
  input logic              ctrl_clk,
  input logic [PTR_W-1:0]  ptr,
  input logic              reading,
  input logic [CNT_W-1:0]  cnt
);
  // R1
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PRS_B] && rd_data[GNT_B]);

  // R2
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[CLK_B] == ctrl_clk)) |=> ($stable(ptr) && $stable(reading)));

  // R3
  fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_clk && !wr_data[CLK_B]) |=> (ptr == $past(ptr) + PTR_W'(1)));

  // R4
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_clk && wr_data[CLK_B] && !wr_data[CS_B])
      |=> (!reading && (cnt == '0) && (ptr == '0)));

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reading |-> rd_data[DO_B]);
endmodule

bind mw_eeprom_resp mw_eeprom_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .ctrl_clk(ctrl_q[0]),
  .ptr     (seq_ptr),
  .reading (seq_reading),
  .cnt     (seq_cnt)
);

// File: tb/mw_eeprom_resp_tb.sv
module mw_eeprom_resp_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        init_we;
  logic [5:0]  init_addr;
  logic [15:0] init_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] model [64];

  mw_eeprom_resp dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .init_we(init_we), .init_addr(init_addr),
    .init_word(init_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {write value, expected read value}; no read is active in this table
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'h0188},
    {16'h0076, 16'h01FE},
    {16'hFE08, 16'h0188},
    {16'h0001, 16'h0189},
    {16'h0003, 16'h018B},
    {16'h0002, 16'h018A},
    {16'h0047, 16'h01CF},
    {16'h0000, 16'h0188}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clk_bit(input logic di);
    reg_wr(16'h0003 | (16'(di) << 2));
    reg_wr(16'h0002 | (16'(di) << 2));
  endtask

  task automatic cmd_start();
    reg_wr(16'h0001);
    reg_wr(16'h0000);
    reg_wr(16'h0002);
  endtask

  task automatic send_bits(input logic [8:0] cmd, input int nb);
    for (int i = 8; i > 8 - nb; i--) clk_bit(cmd[i]);
  endtask

  function automatic logic exp_bit(input int idx);
    int w = (idx >> 4) & 63;
    int b = idx & 15;
    return model[w][15 - b];
  endfunction

  task automatic stream(input string req, input int start, input int nbits, input logic di);
    for (int k = 0; k < nbits; k++) begin
      check(req, 16'(rd_data[3]), 16'(exp_bit((start + k) % 1024)));
      clk_bit(di);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_data = 0; init_we = 0; init_addr = 0; init_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 R8 reset value", rd_data, 16'h0188);

    // table walk: stored bits, status bits, idle data-out
    for (int i = 0; i < 8; i++) begin
      reg_wr(VEC[i][31:16]);
      check("R1 R2 R4 R8 table", rd_data, VEC[i][15:0]);
    end

    // load contents
    for (int i = 0; i < 64; i++) begin
      model[i] = 16'(i * 16'h0421) ^ 16'h9C3A;
      @(negedge clk);
      init_we = 1; init_addr = 6'(i); init_word = model[i];
    end
    @(negedge clk); init_we = 0;

    // read from word 5 across into word 6
    cmd_start();
    send_bits({3'b110, 6'd5}, 9);
    stream("R3 R6 R9 read w5", 5 * 16, 32, 1'b0);

    // wrap 63 -> 0
    cmd_start();
    send_bits({3'b110, 6'd63}, 9);
    stream("R9 wrap", 63 * 16, 24, 1'b0);

    // partial command, then the 9th bit peek at address 0
    cmd_start();
    send_bits({3'b110, 6'd0}, 8);
    check("R5 eight bits no read", 16'(rd_data[3]), 16'd1);
    reg_wr(16'h0003);
    check("R6 pointer A*16-1", 16'(rd_data[3]), 16'(model[63][0]));
    reg_wr(16'h0002);
    check("R6 first bit MSB", 16'(rd_data[3]), 16'(model[0][15]));

    // non-read opcode
    cmd_start();
    send_bits({3'b101, 6'd5}, 9);
    check("R7 other opcode", 16'(rd_data[3]), 16'd1);
    clk_bit(1'b0);
    check("R7 other opcode later", 16'(rd_data[3]), 16'd1);

    // writes without clock change during a read
    cmd_start();
    send_bits({3'b110, 6'd12}, 9);
    check("R2 before", 16'(rd_data[3]), 16'(exp_bit(12 * 16)));
    reg_wr(16'h0006);
    reg_wr(16'h0072);
    reg_wr(16'h0002);
    check("R2 held", 16'(rd_data[3]), 16'(exp_bit(12 * 16)));
    stream("R2 stream resumes", 12 * 16, 8, 1'b0);

    // extra data-in ones during read
    cmd_start();
    send_bits({3'b110, 6'd10}, 9);
    stream("R10 di high during read", 10 * 16, 24, 1'b1);

    // abort mid-read then restart
    cmd_start();
    send_bits({3'b110, 6'd40}, 9);
    stream("R9 pre-abort", 40 * 16, 3, 1'b0);
    reg_wr(16'h0001);
    check("R4 abort", 16'(rd_data[3]), 16'd1);
    reg_wr(16'h0000);
    reg_wr(16'h0002);
    send_bits({3'b110, 6'd33}, 9);
    stream("R4 restart", 33 * 16, 16, 1'b0);

    // init write on the same cycle as a falling edge into the streamed word
    cmd_start();
    send_bits({3'b110, 6'd20}, 9);
    stream("R11 old bits", 20 * 16, 4, 1'b0);
    reg_wr(16'h0003);
    @(negedge clk);
    wr_en = 1; wr_data = 16'h0002;
    init_we = 1; init_addr = 6'd20; init_word = ~model[20];
    @(negedge clk);
    wr_en = 0; init_we = 0;
    model[20] = ~model[20];
    stream("R11 same-cycle load", 20 * 16 + 5, 11, 1'b0);

    // idle reload of a word
    @(negedge clk);
    init_we = 1; init_addr = 6'd7; init_word = 16'h8001;
    @(negedge clk);
    init_we = 0; model[7] = 16'h8001;
    cmd_start();
    send_bits({3'b110, 6'd7}, 9);
    stream("R11 idle load", 7 * 16, 16, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule